// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block turns a bank of external interrupt input pins into interrupt messages for processors. Every pin owns a programmable redirection entry. The entry gives the vector, a 3-bit delivery mode, the input polarity, edge or level triggering, a mask bit and a 16-bit destination. The destination carries the processor id in its upper byte and the extended id in its lower byte. Each pin passes through a synchroniser, and its polarity is applied next. Edge pins latch a pending flag. Level pins are blocked once delivered, until an end-of-interrupt that carries their vector arrives. The pending pin with the lowest number is loaded into a registered valid/ready message port.

Software reaches the block through a select register and a data window. Through the window it reads a version register and reads or writes the two 32-bit words of each entry. A write to the high word is staged. The new destination is used only after the low word of the same entry is written.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Window index 0x01 reads the version register. Bits 7:0 hold the VERSION parameter and bits 23:16 hold NUM_PINS-1. All other bits read 0. Writes to it have no effect.
- R2: After reset, msg_valid is 0. Every entry low word reads 0x0001_0000, meaning masked, vector 0, mode 0 (fixed), edge and active-high. Every high word reads 0.
- R3: Address 0x00 is the select register. It holds an 8-bit index and reads it back in bits 7:0. Address 0x10 is the window. Index 0x10+2n is the low word of entry n: vector in 7:0, mode in 10:8, polarity in 13 (1 = active low), trigger in 15 (1 = level) and mask in 16. Index 0x11+2n is the high word, with the destination in 31:16. Unused bits and unused indexes read 0.
- R4: A high-word write is staged and reads back at once. Messages keep the previous destination until the low word of that entry is written. At that point the staged destination takes effect.
- R5: For an unmasked edge entry, an inactive-to-active change of the input produces exactly one message. The message carries the vector, mode and destination of the entry. msg_valid is first seen after the 4th rising clock edge following the input change. An input held active produces nothing more.
- R6: An edge that occurs while the entry is masked is discarded. Clearing the mask later produces no message for that edge.
- R7: With the polarity bit set, a low input is the active state. A high-to-low change triggers an edge entry.
- R8: An unmasked level entry whose input is active produces a message after the 3rd rising edge. It does not deliver again until an end-of-interrupt carries its vector. If the input is still active at that point it delivers again. If the input is inactive, nothing is sent.
- R9: An end-of-interrupt whose vector matches no blocked level entry has no effect.
- R10: When several pins have a request, the lowest-numbered pin is sent first, with one message per accepted handshake. While msg_valid is high and msg_ready is low, all message fields stay unchanged.
- R11: Every delivery mode code from 0 to 7 is carried unchanged in msg_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NUM_PINS | Asynchronous interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (0x00 select, 0x10 window) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high together with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination {id, extended id} |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
With two synchroniser stages, an edge message is due after the 4th rising edge that follows the input change. A level message is due after the 3rd. A re-delivery after a matching end-of-interrupt is due one edge after the end-of-interrupt is sampled. A register write affects behaviour from the edge that samples it, and reads are combinational. The bench drives every input on the falling edge. It samples every output 1 ns later. On each such sample it compares the outputs with a behavioural model that advances on the rising edge. Directed checks count clock edges from the stimulus to test the exact latencies. They also check the count of delivered messages, and their order and fields, after each scenario.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   // Decoded low word of one redirection entry
   typedef struct packed {
      logic       mask;
      logic       level;
      logic       act_low;
      logic [2:0] mode;
      logic [7:0] vec;
   } rte_low_t;

   localparam logic [4:0] ADDR_SEL     = 5'h00;
   localparam logic [4:0] ADDR_WIN     = 5'h10;
   localparam logic [7:0] IDX_VER      = 8'h01;
   localparam logic [7:0] IDX_RTE_BASE = 8'h10;

   localparam rte_low_t RTE_RESET = '{mask: 1'b1, default: '0};

   function automatic logic [31:0] pack_low(rte_low_t e);
      return {15'd0, e.mask, e.level, 1'b0, e.act_low, 2'b00, e.mode, e.vec};
   endfunction

   function automatic rte_low_t unpack_low(logic [31:0] w);
      rte_low_t e;
      e.mask    = w[16];
      e.level   = w[15];
      e.act_low = w[13];
      e.mode    = w[10:8];
      e.vec     = w[7:0];
      return e;
   endfunction

endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic       mask_i,
   input  logic       level_i,
   input  logic       act_low_i,
   input  logic [7:0] vec_i,
   input  logic       claim_i,
   input  logic       eoi_valid_i,
   input  logic [7:0] eoi_vector_i,
   output logic       req_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pending_q;
   logic                   insvc_q;
   logic                   active;
   logic                   rise;
   logic                   eoi_hit;

   assign active  = sync_q[SYNC_STAGES-1] ^ act_low_i;
   assign rise    = active & ~prev_q;
   assign eoi_hit = eoi_valid_i && (eoi_vector_i == vec_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '0;
         prev_q    <= 1'b0;
         pending_q <= 1'b0;
         insvc_q   <= 1'b0;
      end else begin
         sync_q    <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q    <= active;
         pending_q <= !level_i && ((pending_q && !claim_i) || (rise && !mask_i));
         insvc_q   <= level_i && (claim_i || (insvc_q && !eoi_hit));
      end
   end

   assign req_o = level_i ? (active && !mask_i && !insvc_q) : pending_q;

   // R8
   level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i && insvc_q) |-> !claim_i);

   // R5
   edge_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && claim_i) |-> pending_q);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_i,
   output logic [N-1:0]     grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            idx_o      = IDX_W'(i);
         end
      end
   end

   assign any_o = |req_i;

   // R10
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && ((grant_o & ~req_i) == '0));

   // R10
   grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (((grant_o - 1'b1) & req_i) == '0) && (grant_o != '0));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
   import irq_redir_pkg::*;
#(
   parameter int         NUM_PINS    = 8,
   parameter logic [7:0] VERSION     = 8'h14,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_pins,
   input  logic                reg_wr,
   input  logic [4:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_mode,
   output logic [15:0]         msg_dest,
   input  logic                eoi_valid,
   input  logic [7:0]          eoi_vector
);

   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
         $error("irq_redirect_ctrl: NUM_PINS must be 1..64");
      end
   endgenerate

   logic [7:0]          sel_q;
   logic [7:0]          rte_off;
   logic                in_table;
   logic                win_wr;
   logic [IDX_W-1:0]    ent;
   rte_low_t            rte_arr   [NUM_PINS];
   logic [15:0]         dshad_arr [NUM_PINS];
   logic [15:0]         dlive_arr [NUM_PINS];
   logic [NUM_PINS-1:0] req;
   logic [NUM_PINS-1:0] grant;
   logic [NUM_PINS-1:0] claim;
   logic [IDX_W-1:0]    gidx;
   logic                any_req;
   logic                load;

   assign rte_off  = sel_q - IDX_RTE_BASE;
   assign in_table = (sel_q >= IDX_RTE_BASE) && ({1'b0, rte_off} < 9'(2 * NUM_PINS));
   assign win_wr   = reg_wr && (reg_addr == ADDR_WIN);
   assign ent      = rte_off[IDX_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            sel_q <= '0;
      else if (reg_wr && reg_addr == ADDR_SEL) sel_q <= reg_wdata[7:0];
   end

   // Per-pin entry storage and input conditioning
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         rte_low_t    rte_q;
         logic [15:0] dshad_q;
         logic [15:0] dlive_q;
         logic        hit;

         assign hit = win_wr && in_table && (rte_off[7:1] == 7'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rte_q   <= RTE_RESET;
               dshad_q <= '0;
               dlive_q <= '0;
            end else if (hit) begin
               if (rte_off[0]) begin
                  dshad_q <= reg_wdata[31:16];
               end else begin
                  rte_q   <= unpack_low(reg_wdata);
                  dlive_q <= dshad_q;
               end
            end
         end

         assign rte_arr[i]   = rte_q;
         assign dshad_arr[i] = dshad_q;
         assign dlive_arr[i] = dlive_q;

         irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
            .clk          (clk),
            .rst_n        (rst_n),
            .pin_i        (irq_pins[i]),
            .mask_i       (rte_q.mask),
            .level_i      (rte_q.level),
            .act_low_i    (rte_q.act_low),
            .vec_i        (rte_q.vec),
            .claim_i      (claim[i]),
            .eoi_valid_i  (eoi_valid),
            .eoi_vector_i (eoi_vector),
            .req_o        (req[i])
         );
      end
   endgenerate

   irq_prio_arb #(.N(NUM_PINS), .IDX_W(IDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .grant_o (grant),
      .idx_o   (gidx),
      .any_o   (any_req)
   );

   assign load  = any_req && (!msg_valid || msg_ready);
   assign claim = grant & {NUM_PINS{load}};

   // Registered message port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_vector <= '0;
         msg_mode   <= '0;
         msg_dest   <= '0;
      end else if (load) begin
         msg_valid  <= 1'b1;
         msg_vector <= rte_arr[gidx].vec;
         msg_mode   <= rte_arr[gidx].mode;
         msg_dest   <= dlive_arr[gidx];
      end else if (msg_ready) begin
         msg_valid  <= 1'b0;
      end
   end

   // Read path
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_SEL) begin
         reg_rdata = {24'd0, sel_q};
      end else if (reg_addr == ADDR_WIN) begin
         if (sel_q == IDX_VER)
            reg_rdata = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
         else if (in_table)
            reg_rdata = rte_off[0] ? {dshad_arr[ent], 16'd0} : pack_low(rte_arr[ent]);
      end
   end

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_vector)
                                    && $stable(msg_mode) && $stable(msg_dest));

endmodule

// File: tb/irq_redirect_ctrl_test.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_test;

   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] irq_pins = '0;
   logic          reg_wr = 1'b0;
   logic [4:0]    reg_addr = 5'h10;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [7:0]    msg_vector;
   logic [2:0]    msg_mode;
   logic [15:0]   msg_dest;
   logic          eoi_valid = 1'b0;
   logic [7:0]    eoi_vector = '0;

   int    checks = 0;
   int    errors = 0;
   bit    started = 0;
   bit    done = 0;
   string cur_req = "R2";

   int          cnt [256];
   logic [15:0] last_dest [256];
   logic [2:0]  last_mode [256];
   int          order [$];

   always #2.5 clk = ~clk;

   irq_redirect_ctrl #(.NUM_PINS(NP), .VERSION(8'h14), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest(msg_dest),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [7:0]  m_sel;
   bit [31:0] m_low [NP];
   bit [15:0] m_dsh [NP];
   bit [15:0] m_dlv [NP];
   bit        m_s1 [NP];
   bit        m_s2 [NP];
   bit        m_prev [NP];
   bit        m_pend [NP];
   bit        m_isv [NP];
   bit        m_ov;
   bit [7:0]  m_ovec;
   bit [2:0]  m_omode;
   bit [15:0] m_odest;

   always @(posedge clk or negedge rst_n) begin : model
      bit act [NP];
      bit rise [NP];
      bit rq [NP];
      bit any;
      bit ld;
      bit cl;
      bit hit;
      int g;
      int n;
      if (!rst_n) begin
         m_sel = 0;
         m_ov  = 0;
         for (int i = 0; i < NP; i++) begin
            m_low[i] = 32'h0001_0000; m_dsh[i] = 0; m_dlv[i] = 0;
            m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0; m_isv[i] = 0;
         end
      end else begin
         any = 0; g = 0;
         for (int i = 0; i < NP; i++) begin
            act[i]  = m_s2[i] ^ m_low[i][13];
            rise[i] = act[i] && !m_prev[i];
            rq[i]   = m_low[i][15] ? (act[i] && !m_low[i][16] && !m_isv[i]) : m_pend[i];
         end
         for (int i = NP - 1; i >= 0; i--) if (rq[i]) begin any = 1; g = i; end
         ld = any && (!m_ov || msg_ready);
         for (int i = 0; i < NP; i++) begin
            cl  = ld && (g == i);
            hit = eoi_valid && (eoi_vector == m_low[i][7:0]);
            if (m_low[i][15]) begin
               m_pend[i] = 0;
               m_isv[i]  = cl || (m_isv[i] && !hit);
            end else begin
               m_pend[i] = (m_pend[i] && !cl) || (rise[i] && !m_low[i][16]);
               m_isv[i]  = 0;
            end
            m_prev[i] = act[i];
            m_s2[i]   = m_s1[i];
            m_s1[i]   = irq_pins[i];
         end
         if (ld) begin
            m_ov = 1; m_ovec = m_low[g][7:0]; m_omode = m_low[g][10:8]; m_odest = m_dlv[g];
         end else if (msg_ready) begin
            m_ov = 0;
         end
         if (reg_wr) begin
            if (reg_addr == 5'h00) m_sel = reg_wdata[7:0];
            else if (reg_addr == 5'h10 && m_sel >= 8'h10 && m_sel < 8'h10 + 2 * NP) begin
               n = (m_sel - 8'h10) / 2;
               if (m_sel[0]) m_dsh[n] = reg_wdata[31:16];
               else begin
                  m_low[n] = reg_wdata & 32'h0001_A7FF;
                  m_dlv[n] = m_dsh[n];
               end
            end
         end
      end
   end

   // Per-cycle comparison and handshake monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && started) begin
         chk({cur_req, " valid"}, 32'(msg_valid), 32'(m_ov));
         if (m_ov) begin
            chk({cur_req, " vector"}, 32'(msg_vector), 32'(m_ovec));
            chk({cur_req, " mode"}, 32'(msg_mode), 32'(m_omode));
            chk({cur_req, " dest"}, 32'(msg_dest), 32'(m_odest));
         end
         if (msg_valid && msg_ready) begin
            cnt[msg_vector]++;
            last_dest[msg_vector] = msg_dest;
            last_mode[msg_vector] = msg_mode;
            order.push_back(int'(msg_vector));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] mk_low(bit mask, bit level, bit act_low,
                                          logic [2:0] mode, logic [7:0] vec);
      return {15'd0, mask, level, 1'b0, act_low, 2'b00, mode, vec};
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 5'h10;
   endtask

   task automatic wr_idx(logic [7:0] idx, logic [31:0] d);
      wr(5'h00, {24'd0, idx});
      wr(5'h10, d);
   endtask

   task automatic rd_idx(logic [7:0] idx, logic [31:0] exp, string tag);
      wr(5'h00, {24'd0, idx});
      reg_addr = 5'h10;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic prog(int n, logic [15:0] dest, logic [31:0] low);
      wr_idx(8'(8'h11 + 2 * n), {dest, 16'h0000});
      wr_idx(8'(8'h10 + 2 * n), low);
   endtask

   task automatic set_pin(int i, logic v);
      @(negedge clk);
      irq_pins[i] = v;
   endtask

   task automatic eoi(logic [7:0] v);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      for (int i = 0; i < 256; i++) begin cnt[i] = 0; last_dest[i] = 0; last_mode[i] = 0; end
      tick(3);
      rst_n = 1'b1;
      started = 1'b1;
      tick(2);

      // R2 reset state
      #1;
      chk("R2 msg_valid after reset", 32'(msg_valid), 32'd0);
      for (int i = 0; i < NP; i++) begin
         rd_idx(8'(8'h10 + 2 * i), 32'h0001_0000, "R2 reset low word");
         rd_idx(8'(8'h11 + 2 * i), 32'h0000_0000, "R2 reset high word");
      end

      // R1 version register
      cur_req = "R1";
      rd_idx(8'h01, 32'h0007_0014, "R1 version");
      wr(5'h10, 32'hFFFF_FFFF);
      rd_idx(8'h01, 32'h0007_0014, "R1 version after write");

      // R3 select and window layout
      cur_req = "R3";
      wr(5'h00, 32'h0000_0013);
      reg_addr = 5'h00; #1;
      chk("R3 select readback", reg_rdata, 32'h0000_0013);
      wr_idx(8'h16, 32'hFFFF_FFFF);
      rd_idx(8'h16, 32'h0001_A7FF, "R3 low word field mask");
      wr_idx(8'h17, 32'hFFFF_FFFF);
      rd_idx(8'h17, 32'hFFFF_0000, "R3 high word field");
      rd_idx(8'h02, 32'h0000_0000, "R3 unused index");
      rd_idx(8'h20, 32'h0000_0000, "R3 index beyond table");
      wr_idx(8'h16, mk_low(1, 0, 0, 3'd0, 8'h00));

      // R4 staged destination
      cur_req = "R4";
      prog(0, 16'h1234, mk_low(0, 0, 0, 3'd1, 8'h40));
      set_pin(0, 1); tick(8); set_pin(0, 0); tick(4);
      chk("R4 first dest", 32'(last_dest[8'h40]), 32'h1234);
      wr_idx(8'h11, 32'hBEEF_0000);
      rd_idx(8'h11, 32'hBEEF_0000, "R4 staged high readback");
      set_pin(0, 1); tick(8); set_pin(0, 0); tick(4);
      chk("R4 dest before low write", 32'(last_dest[8'h40]), 32'h1234);
      wr_idx(8'h10, mk_low(0, 0, 0, 3'd1, 8'h40));
      set_pin(0, 1); tick(8); set_pin(0, 0); tick(4);
      chk("R4 dest after low write", 32'(last_dest[8'h40]), 32'hBEEF);
      chk("R4 message count", 32'(cnt[8'h40]), 32'd3);

      // R5 edge delivery and latency
      cur_req = "R5";
      prog(1, 16'h0102, mk_low(0, 0, 0, 3'd0, 8'h41));
      tick(4);
      set_pin(1, 1);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R5 not valid after 3 edges", 32'(msg_valid), 32'd0);
      @(posedge clk);
      @(negedge clk); #1;
      chk("R5 valid after 4 edges", 32'(msg_valid), 32'd1);
      chk("R5 vector", 32'(msg_vector), 32'h41);
      tick(12);
      chk("R5 single message while held", 32'(cnt[8'h41]), 32'd1);
      chk("R5 dest", 32'(last_dest[8'h41]), 32'h0102);
      set_pin(1, 0); tick(4);

      // R6 masked edge dropped
      cur_req = "R6";
      prog(2, 16'h0200, mk_low(1, 0, 0, 3'd0, 8'h42));
      set_pin(2, 1); tick(8);
      wr_idx(8'h14, mk_low(0, 0, 0, 3'd0, 8'h42));
      tick(10);
      chk("R6 masked edge not sent", 32'(cnt[8'h42]), 32'd0);
      set_pin(2, 0); tick(4);
      set_pin(2, 1); tick(8);
      chk("R6 later edge sent", 32'(cnt[8'h42]), 32'd1);
      set_pin(2, 0); tick(4);

      // R7 active-low polarity
      cur_req = "R7";
      set_pin(3, 1); tick(4);
      prog(3, 16'h0300, mk_low(0, 0, 1, 3'd0, 8'h43));
      tick(8);
      chk("R7 idle high no message", 32'(cnt[8'h43]), 32'd0);
      set_pin(3, 0); tick(8);
      chk("R7 falling edge sent", 32'(cnt[8'h43]), 32'd1);
      set_pin(3, 1); tick(8);
      chk("R7 rising edge ignored", 32'(cnt[8'h43]), 32'd1);

      // R8 and R9 level with end-of-interrupt
      cur_req = "R8";
      prog(4, 16'h0400, mk_low(0, 1, 0, 3'd2, 8'h44));
      tick(4);
      set_pin(4, 1);
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      chk("R8 not valid after 2 edges", 32'(msg_valid), 32'd0);
      @(posedge clk);
      @(negedge clk); #1;
      chk("R8 valid after 3 edges", 32'(msg_valid), 32'd1);
      tick(12);
      chk("R8 blocked until eoi", 32'(cnt[8'h44]), 32'd1);
      cur_req = "R9";
      eoi(8'h55); tick(10);
      chk("R9 foreign eoi ignored", 32'(cnt[8'h44]), 32'd1);
      cur_req = "R8";
      eoi(8'h44); tick(10);
      chk("R8 redelivered while active", 32'(cnt[8'h44]), 32'd2);
      set_pin(4, 0); tick(4);
      eoi(8'h44); tick(10);
      chk("R8 inactive after eoi no message", 32'(cnt[8'h44]), 32'd2);

      // R10 priority and hold while stalled
      cur_req = "R10";
      prog(5, 16'h0500, mk_low(0, 0, 0, 3'd0, 8'h45));
      prog(6, 16'h0600, mk_low(0, 0, 0, 3'd0, 8'h46));
      prog(7, 16'h0700, mk_low(0, 0, 0, 3'd0, 8'h47));
      tick(4);
      order.delete();
      @(negedge clk); msg_ready = 1'b0;
      set_pin(7, 1); tick(8);
      #1;
      chk("R10 first held vector", 32'(msg_vector), 32'h47);
      @(negedge clk);
      irq_pins[5] = 1'b1; irq_pins[6] = 1'b1;
      tick(8);
      #1;
      chk("R10 stalled vector unchanged", 32'(msg_vector), 32'h47);
      chk("R10 stalled valid", 32'(msg_valid), 32'd1);
      @(negedge clk); msg_ready = 1'b1;
      tick(8);
      chk("R10 message count", 32'(order.size()), 32'd3);
      if (order.size() == 3) begin
         chk("R10 order first", 32'(order[0]), 32'h47);
         chk("R10 order second lowest pin", 32'(order[1]), 32'h45);
         chk("R10 order third", 32'(order[2]), 32'h46);
      end
      @(negedge clk);
      irq_pins[5] = 1'b0; irq_pins[6] = 1'b0; irq_pins[7] = 1'b0;
      tick(4);

      // R11 delivery mode pass-through
      cur_req = "R11";
      for (int m = 0; m < 8; m++) begin
         prog(5, 16'h0A0B, mk_low(0, 0, 0, 3'(m), 8'(8'h50 + m)));
         set_pin(5, 1); tick(8); set_pin(5, 0); tick(3);
         chk("R11 mode carried", 32'(last_mode[8'h50 + m]), 32'(m));
         chk("R11 one message", 32'(cnt[8'h50 + m]), 32'd1);
      end

      tick(4);
      done = 1'b1;
      finish_run();
   end

endmodule